// File: doc/BRIEF.md
# DMA Major-Loop Completion Controller

This block decides what one DMA channel does at the moment its major iteration count runs out. When the channel's engine signals that the major loop is finished, the controller captures the channel's 16-bit control/status word and its last-address/scatter-gather pointer. It then writes back an updated status word with the completion bit set and the busy bit cleared. It can raise a completion interrupt and can drop the channel's hardware request enable.

Next, the controller picks what follows. If scatter-gather is enabled, it requests a reload of the next descriptor from the pointer. That pointer must sit on a 32-byte boundary. If it does not, the controller flags a configuration error and does nothing else. If linking is enabled, it asks the arbiter to start another channel, chosen by a 4-bit field of the status word. When both are enabled, the link request waits until the reload has been acknowledged.

The memory fetch and the channel arbitration sit outside the block. Both are reached through plain level request / one-cycle acknowledge handshakes.

Top module: `dma_major_done_ctrl`

## Requirements
- R1: With scatter-gather enabled (control bit 4) and a pointer whose low five bits are not all zero, a completion pulse makes `cfg_err_o` high for exactly the next cycle. In that case no fetch, no link, no status write, no interrupt and no request-enable clear is produced.
- R2: With scatter-gather enabled and an aligned pointer, `fetch_req_o` rises in the cycle after the completion pulse, and `fetch_addr_o` equals the captured pointer.
- R3: `fetch_req_o` and `fetch_addr_o` stay unchanged until `fetch_ack_i` is seen; the request drops in the cycle after the acknowledge.
- R4: Every completion without a configuration error gives a one-cycle `status_we_o` in the cycle after the pulse. Its `status_o` is the captured word with bit 7 (done) set, bit 6 (active) cleared, bits 13–12 forced to zero, and every other bit unchanged.
- R5: `irq_o` pulses together with `status_we_o` exactly when the interrupt-on-major bit (bit 1) of the captured word is set.
- R6: `hw_req_clr_o` pulses together with `status_we_o` exactly when the request-disable bit (bit 3) of the captured word is set.
- R7: With linking enabled (bit 5) and scatter-gather disabled, `link_req_o` rises in the cycle after the pulse and holds until `link_ack_i`. `link_ch_o` carries bits 11–8 of the captured word.
- R8: With the link bit clear, no link request is ever made.
- R9: With both scatter-gather and linking enabled, `link_req_o` stays low while the fetch is pending. It rises in the cycle after `fetch_ack_i`.
- R10: A completion pulse that arrives while a fetch or link request is pending is ignored. It produces no error, no status write and no change to the pending request.
- R11: With scatter-gather disabled, the pointer is not checked, so an unaligned pointer raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_i | input | 16 | Channel control/status word at completion |
| sga_i | input | 32 | Last-address / scatter-gather pointer |
| major_done_i | input | 1 | One-cycle major-loop completion pulse |
| fetch_req_o | output | 1 | Descriptor reload request (level) |
| fetch_addr_o | output | 32 | Address of the descriptor to load |
| fetch_ack_i | input | 1 | Reload accepted |
| link_req_o | output | 1 | Channel link request (level) |
| link_ch_o | output | 4 | Target channel of the link |
| link_ack_i | input | 1 | Link accepted |
| cfg_err_o | output | 1 | Misaligned scatter-gather pointer pulse |
| irq_o | output | 1 | Major-completion interrupt pulse |
| hw_req_clr_o | output | 1 | Clear the channel's hardware request enable |
| status_we_o | output | 1 | Status write-back strobe |
| status_o | output | 16 | Updated control/status word |

## Verification
The hardest cases to reach are a second completion pulse arriving while a reload is still waiting, and the ordering of a link behind a reload. Both need the acknowledge inputs to be held low on purpose. The bench keeps `fetch_ack_i` low for several cycles and, during that wait, injects a pulse whose word and pointer would otherwise cause an error. It checks that nothing moves. Only then does it release the acknowledge and watch the link request come up one cycle later.

// File: rtl/dma_mdc_pkg.sv
package dma_mdc_pkg;

    // Bit positions within the channel control/status word
    localparam int unsigned B_START    = 0;
    localparam int unsigned B_INTMAJOR = 1;
    localparam int unsigned B_INTHALF  = 2;
    localparam int unsigned B_DREQ     = 3;
    localparam int unsigned B_ESG      = 4;
    localparam int unsigned B_ELINK    = 5;
    localparam int unsigned B_ACTIVE   = 6;
    localparam int unsigned B_DONE     = 7;
    localparam int unsigned B_LINK_LO  = 8;
    localparam int unsigned B_RSVD_LO  = 12;
    localparam int unsigned B_RSVD_HI  = 13;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LINK  = 2'd2
    } mdc_state_e;

endpackage

// File: rtl/mdc_sga_check.sv
module mdc_sga_check #(
    parameter int unsigned LOWB = 5
) (
    input  logic [LOWB-1:0] low_i,
    output logic            aligned_o
);
    always_comb begin
        aligned_o = (low_i == '0);
    end
endmodule

// File: rtl/mdc_status_upd.sv
module mdc_status_upd
    import dma_mdc_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic [CW-1:0] csr_i,
    output logic [CW-1:0] status_o
);
    always_comb begin
        status_o = csr_i;
        for (int i = int'(B_RSVD_LO); i <= int'(B_RSVD_HI); i++) begin
            status_o[i] = 1'b0;
        end
        status_o[B_DONE]   = 1'b1;
        status_o[B_ACTIVE] = 1'b0;
    end
endmodule

// File: rtl/dma_major_done_ctrl.sv
module dma_major_done_ctrl
    import dma_mdc_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned CW          = 16,
    parameter int unsigned NCH         = 16,
    parameter int unsigned ALIGN_BYTES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CW-1:0]          csr_i,
    input  logic [AW-1:0]          sga_i,
    input  logic                   major_done_i,
    output logic                   fetch_req_o,
    output logic [AW-1:0]          fetch_addr_o,
    input  logic                   fetch_ack_i,
    output logic                   link_req_o,
    output logic [$clog2(NCH)-1:0] link_ch_o,
    input  logic                   link_ack_i,
    output logic                   cfg_err_o,
    output logic                   irq_o,
    output logic                   hw_req_clr_o,
    output logic                   status_we_o,
    output logic [CW-1:0]          status_o
);
    localparam int unsigned CHW  = $clog2(NCH);
    localparam int unsigned LOWB = $clog2(ALIGN_BYTES);

    typedef struct packed {
        mdc_state_e    st;
        logic [CW-1:0] csr;
        logic [AW-1:0] sga;
        logic          err;
        logic          we;
        logic          irq;
        logic          clr;
    } mdc_regs_t;

    mdc_regs_t q, d;
    logic      sga_ok;

    mdc_sga_check #(.LOWB(LOWB)) u_align (
        .low_i     (sga_i[LOWB-1:0]),
        .aligned_o (sga_ok)
    );

    mdc_status_upd #(.CW(CW)) u_stat (
        .csr_i    (q.csr),
        .status_o (status_o)
    );

    always_comb begin
        d     = q;
        d.err = 1'b0;
        d.we  = 1'b0;
        d.irq = 1'b0;
        d.clr = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (major_done_i) begin
                    d.csr = csr_i;
                    d.sga = sga_i;
                    if (csr_i[B_ESG] && !sga_ok) begin
                        d.err = 1'b1;
                    end else begin
                        d.we  = 1'b1;
                        d.irq = csr_i[B_INTMAJOR];
                        d.clr = csr_i[B_DREQ];
                        if (csr_i[B_ESG]) begin
                            d.st = ST_FETCH;
                        end else if (csr_i[B_ELINK]) begin
                            d.st = ST_LINK;
                        end
                    end
                end
            end
            ST_FETCH: begin
                if (fetch_ack_i) begin
                    d.st = q.csr[B_ELINK] ? ST_LINK : ST_IDLE;
                end
            end
            ST_LINK: begin
                if (link_ack_i) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, csr: '0, sga: '0, err: 1'b0,
                   we: 1'b0, irq: 1'b0, clr: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        fetch_req_o  = (q.st == ST_FETCH);
        fetch_addr_o = q.sga;
        link_req_o   = (q.st == ST_LINK);
        link_ch_o    = q.csr[B_LINK_LO +: CHW];
        cfg_err_o    = q.err;
        irq_o        = q.irq;
        hw_req_clr_o = q.clr;
        status_we_o  = q.we;
    end
endmodule

// File: rtl/mdc_checker.sv
module mdc_checker
    import dma_mdc_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned CW   = 16,
    parameter int unsigned CHW  = 4,
    parameter int unsigned LOWB = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CW-1:0]   csr_i,
    input logic [LOWB-1:0] sga_low_i,
    input logic            major_done_i,
    input logic            fetch_req_o,
    input logic [AW-1:0]   fetch_addr_o,
    input logic            fetch_ack_i,
    input logic            link_req_o,
    input logic [CHW-1:0]  link_ch_o,
    input logic            link_ack_i,
    input logic            cfg_err_o,
    input logic            irq_o,
    input logic            hw_req_clr_o,
    input logic            status_we_o,
    input logic [CW-1:0]   status_o
);
    logic idle;
    assign idle = !fetch_req_o && !link_req_o;

    // R1
    a_r1_err_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        idle && major_done_i && csr_i[B_ESG] && (sga_low_i != '0) |=> cfg_err_o);
    a_r1_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !fetch_req_o && !link_req_o && !status_we_o && !irq_o && !hw_req_clr_o);
    // R3
    a_r3_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o && !fetch_ack_i |=> fetch_req_o && $stable(fetch_addr_o));
    // R7
    a_r7_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
        link_req_o && !link_ack_i |=> link_req_o && $stable(link_ch_o));
    // R4
    a_r4_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        status_we_o |-> status_o[B_DONE] && !status_o[B_ACTIVE]
                        && !status_o[B_RSVD_HI] && !status_o[B_RSVD_LO]);
    // R5, R6
    a_r5_irq_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> status_we_o && status_o[B_INTMAJOR]);
    a_r6_clr_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        hw_req_clr_o |-> status_we_o && status_o[B_DREQ]);
    // R9
    a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req_o && link_req_o));
    // R10
    a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> !status_we_o && !cfg_err_o);
endmodule

bind dma_major_done_ctrl mdc_checker #(
    .AW(AW), .CW(CW), .CHW($clog2(NCH)), .LOWB($clog2(ALIGN_BYTES))
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_i        (csr_i),
    .sga_low_i    (sga_i[$clog2(ALIGN_BYTES)-1:0]),
    .major_done_i (major_done_i),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .fetch_ack_i  (fetch_ack_i),
    .link_req_o   (link_req_o),
    .link_ch_o    (link_ch_o),
    .link_ack_i   (link_ack_i),
    .cfg_err_o    (cfg_err_o),
    .irq_o        (irq_o),
    .hw_req_clr_o (hw_req_clr_o),
    .status_we_o  (status_we_o),
    .status_o     (status_o)
);

// File: tb/sim_dma_major_done_ctrl.sv
`timescale 1ns/1ps
module sim_dma_major_done_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] csr = '0;
    logic [31:0] sga = '0;
    logic        md = 1'b0;
    logic        fack = 1'b0;
    logic        lack = 1'b0;
    logic        freq, lreq, err, irq, clr, we;
    logic [31:0] faddr;
    logic [3:0]  lch;
    logic [15:0] stat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_major_done_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .csr_i(csr), .sga_i(sga),
        .major_done_i(md), .fetch_req_o(freq), .fetch_addr_o(faddr),
        .fetch_ack_i(fack), .link_req_o(lreq), .link_ch_o(lch),
        .link_ack_i(lack), .cfg_err_o(err), .irq_o(irq),
        .hw_req_clr_o(clr), .status_we_o(we), .status_o(stat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive a one-cycle completion pulse; returns at the negedge after it was taken.
    task automatic pulse(input logic [15:0] c, input logic [31:0] p);
        @(negedge clk);
        csr = c; sga = p; md = 1'b1;
        @(negedge clk);
        md = 1'b0;
    endtask

    task automatic t_reset;
        chk("R4 reset we", {31'd0, we}, 0);
        chk("R2 reset fetch", {31'd0, freq}, 0);
        chk("R7 reset link", {31'd0, lreq}, 0);
        chk("R1 reset err", {31'd0, err}, 0);
    endtask

    task automatic t_misalign;
        pulse(16'h0010, 32'h0000_1004);
        chk("R1 err", {31'd0, err}, 1);
        chk("R1 no fetch", {31'd0, freq}, 0);
        chk("R1 no write", {31'd0, we}, 0);
        chk("R1 no link", {31'd0, lreq}, 0);
        @(negedge clk);
        chk("R1 err one cycle", {31'd0, err}, 0);
        chk("R1 still no fetch", {31'd0, freq}, 0);
    endtask

    task automatic t_reload;
        pulse(16'hF05A, 32'h2000_0040);
        chk("R4 write", {31'd0, we}, 1);
        chk("R4 status", {16'd0, stat}, 32'h0000_C09A);
        chk("R5 irq", {31'd0, irq}, 1);
        chk("R6 clr", {31'd0, clr}, 1);
        chk("R2 fetch", {31'd0, freq}, 1);
        chk("R2 addr", faddr, 32'h2000_0040);
        chk("R8 no link", {31'd0, lreq}, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 hold", {31'd0, freq}, 1);
            chk("R3 addr", faddr, 32'h2000_0040);
            chk("R4 single write", {31'd0, we}, 0);
        end
        // R10: second pulse while reload pending, misaligned pointer
        pulse(16'h0032, 32'h0000_0007);
        chk("R10 no err", {31'd0, err}, 0);
        chk("R10 no write", {31'd0, we}, 0);
        chk("R10 addr kept", faddr, 32'h2000_0040);
        @(negedge clk);
        fack = 1'b1;
        @(negedge clk);
        fack = 1'b0;
        chk("R3 drop", {31'd0, freq}, 0);
        chk("R8 still no link", {31'd0, lreq}, 0);
    endtask

    task automatic t_link_only;
        pulse(16'h0A20, 32'h0000_0013);
        chk("R11 no err", {31'd0, err}, 0);
        chk("R11 no fetch", {31'd0, freq}, 0);
        chk("R4 status link", {16'd0, stat}, 32'h0000_0AA0);
        chk("R5 no irq", {31'd0, irq}, 0);
        chk("R6 no clr", {31'd0, clr}, 0);
        chk("R7 link", {31'd0, lreq}, 1);
        chk("R7 channel", {28'd0, lch}, 10);
        @(negedge clk);
        chk("R7 hold", {31'd0, lreq}, 1);
        lack = 1'b1;
        @(negedge clk);
        lack = 1'b0;
        chk("R7 drop", {31'd0, lreq}, 0);
    endtask

    task automatic t_reload_then_link;
        pulse(16'h0530, 32'h0000_0100);
        chk("R9 fetch first", {31'd0, freq}, 1);
        chk("R9 link waits", {31'd0, lreq}, 0);
        @(negedge clk);
        chk("R9 link still waits", {31'd0, lreq}, 0);
        fack = 1'b1;
        @(negedge clk);
        fack = 1'b0;
        chk("R9 fetch done", {31'd0, freq}, 0);
        chk("R9 link up", {31'd0, lreq}, 1);
        chk("R9 channel", {28'd0, lch}, 5);
        lack = 1'b1;
        @(negedge clk);
        lack = 1'b0;
        chk("R9 link done", {31'd0, lreq}, 0);
    endtask

    task automatic t_plain;
        pulse(16'h0003, 32'h0000_0001);
        chk("R4 plain write", {31'd0, we}, 1);
        chk("R4 plain status", {16'd0, stat}, 32'h0000_0083);
        chk("R5 plain irq", {31'd0, irq}, 1);
        chk("R6 plain no clr", {31'd0, clr}, 0);
        chk("R11 plain no err", {31'd0, err}, 0);
        @(negedge clk);
        chk("R8 plain no link", {31'd0, lreq}, 0);
        chk("R2 plain no fetch", {31'd0, freq}, 0);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_misalign();
        t_reload();
        t_link_only();
        t_reload_then_link();
        t_plain();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule